// File: doc/BRIEF.md
# Excess-256 Floating-Point Multiplier

This block multiplies two 32-bit floating-point words and returns a 32-bit product in the same format. Bit 31 is the sign. Bits 30:22 hold a 9-bit exponent stored with a bias of +256, so the unbiased range is -256 to +255. Bits 21:0 hold the fraction. Every nonzero value has an implied leading 1 in front of the fraction. A word whose exponent and fraction fields are both zero is zero, whatever its sign bit says.

The unit is sequential. When idle, a one-cycle `start` pulse latches both operands. The unit unpacks them, adds their unbiased exponents and combines their signs. It then forms the 23x23-bit mantissa product with a shift-and-add loop that handles one multiplier bit per cycle, starting from the least significant bit. A final cycle normalizes, rounds and packs the product, and reports an exponent range fault as a trap code. The caller watches `busy` and takes the product when `done` pulses.

Top module: `fpm_mul`

## Requirements
- R1: While reset is held, and after it is released, `busy` and `done` are 0, and `result` and `trap` are 0.
- R2: An operand whose bits 30:0 are all zero is zero for either sign. If either operand is zero, the product is 0x00000000 and the trap code is 0.
- R3: For nonzero operands, result bit 31 is the exclusive-OR of the two operand sign bits.
- R4: The unbiased product exponent is the sum of the unbiased operand exponents (field minus 256). If the 46-bit mantissa product is 2.0 or more, it is shifted right once and the exponent is incremented.
- R5: Rounding adds one half of the fraction LSB and truncates the bits below it, with no sticky bit. A carry out of rounding increments the exponent and leaves a zero fraction.
- R6: Trap code 1 (underflow) is reported when the final exponent is below -256, or equals -256 with a zero fraction. The result word still carries the low 9 bits of the biased exponent. Trap code 3 never occurs.
- R7: Trap code 2 (overflow) is reported when the final exponent is above +255. Otherwise the trap code is 0 (none).
- R8: A `start` that is sampled while idle is accepted. `busy` is high from the following cycle until `done` rises. `done` is a single-cycle pulse that appears 24 clock edges after the accepting edge, and `busy` and `done` are never high together.
- R9: A `start` pulse while `busy` is high is ignored. The operation in flight completes with its original operands and timing.
- R10: `result` and `trap` change only in the cycle `done` is high, and hold their value until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a multiply with the current operands (honoured only when idle) |
| op_a | input | 32 | Multiplicand word |
| op_b | input | 32 | Multiplier word |
| busy | output | 1 | Multiply in progress |
| done | output | 1 | One-cycle pulse: `result` and `trap` are new |
| result | output | 32 | Packed product word |
| trap | output | 2 | 0 none, 1 underflow, 2 overflow |

## Verification
The assertions assume `start` is a synchronous input and that the operands are stable at the clock edge where a start is accepted. They do not assume the operands stay stable afterwards, because the unit captures everything it needs at that edge. The bench changes the operand inputs and raises `start` mid-operation, which exercises the claim that a start while busy is ignored. The directed vectors sit at the exponent edges -256 and +255, both zero encodings, renormalization and a rounding carry. Random words fill in the rest, and the only constraint on them is the one-cycle start pulse.

// File: rtl/fpm_pkg.sv
// fpm_pkg: shared types for the excess-256 multiplier.
// Assumes: nothing; pure type definitions.
package fpm_pkg;

    // Trap codes reported with the product
    typedef enum logic [1:0] {
        TRAP_NONE  = 2'd0,
        TRAP_UNDER = 2'd1,
        TRAP_OVER  = 2'd2
    } trap_e;

    // Sequencer states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_PACK = 2'd2
    } state_e;

endpackage

// File: rtl/fpm_unpack.sv
// fpm_unpack: splits a packed word into sign, unbiased exponent and
// mantissa with the hidden bit restored.
// Assumes: zero is exponent and fraction fields all zero, any sign.
module fpm_unpack #(
    parameter int EXP_W  = 9,
    parameter int FRAC_W = 22
) (
    input  logic [EXP_W+FRAC_W:0]     word,
    output logic                      sign,
    output logic signed [EXP_W+1:0]   exp_u,
    output logic [FRAC_W:0]           mant,
    output logic                      is_zero
);
    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int EW     = EXP_W + 2;
    localparam logic signed [EW-1:0] BIAS = EW'(1 << (EXP_W - 1));

    logic [EXP_W-1:0]  field;
    logic [FRAC_W-1:0] frac;

    // Field extraction and hidden-bit restoration
    always_comb begin
        field   = word[WORD_W-2 -: EXP_W];
        frac    = word[FRAC_W-1:0];
        is_zero = (field == '0) && (frac == '0);
        sign    = word[WORD_W-1];
        exp_u   = $signed({2'b00, field}) - BIAS;
        mant    = is_zero ? '0 : {1'b1, frac};
    end
endmodule

// File: rtl/fpm_shift_add.sv
// fpm_shift_add: unsigned N x N multiplier, one partial product per step,
// multiplier examined from its LSB.
// Assumes: step is asserted exactly N times after load.
module fpm_shift_add #(
    parameter int N = 23
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           step,
    input  logic [N-1:0]   mcand_in,
    input  logic [N-1:0]   mplier_in,
    output logic [2*N-1:0] prod,
    output logic           last
);
    localparam int CW = $clog2(N + 1);

    logic [2*N-1:0] mc_q;
    logic [N-1:0]   mp_q;
    logic [CW-1:0]  cnt_q;

    // Accumulate the shifted multiplicand when the current multiplier bit is 1
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod  <= '0;
            mc_q  <= '0;
            mp_q  <= '0;
            cnt_q <= '0;
        end else if (load) begin
            prod  <= '0;
            mc_q  <= {{N{1'b0}}, mcand_in};
            mp_q  <= mplier_in;
            cnt_q <= '0;
        end else if (step) begin
            if (mp_q[0]) prod <= prod + mc_q;
            mc_q  <= mc_q << 1;
            mp_q  <= mp_q >> 1;
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Flag the final partial product
    always_comb last = (cnt_q == CW'(N - 1));

    AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (cnt_q < CW'(N))); // R8
endmodule

// File: rtl/fpm_pack.sv
// fpm_pack: normalizes the raw product (one right shift at most), rounds
// by half an LSB, packs the word and classifies the exponent.
// Assumes: prod is the product of two mantissas with hidden bits set,
// so bit 2N-1 or bit 2N-2 is one unless the zero flag is set.
module fpm_pack #(
    parameter int EXP_W  = 9,
    parameter int FRAC_W = 22
) (
    input  logic [2*FRAC_W+1:0]     prod,
    input  logic signed [EXP_W+1:0] exp_sum,
    input  logic                    sign,
    input  logic                    zero,
    output logic [EXP_W+FRAC_W:0]   word,
    output logic [1:0]              trap
);
    import fpm_pkg::*;

    localparam int N  = FRAC_W + 1;
    localparam int P  = 2 * N;
    localparam int EW = EXP_W + 2;
    localparam logic signed [EW-1:0] BIAS  = EW'(1 << (EXP_W - 1));
    localparam logic signed [EW-1:0] E_MIN = -BIAS;
    localparam logic signed [EW-1:0] E_MAX = BIAS - 1;

    logic                   high;
    logic [N-1:0]           keep;
    logic                   rbit;
    logic [N:0]             rsum;
    logic signed [EW-1:0]   inc;
    logic signed [EW-1:0]   e_fin;
    logic signed [EW-1:0]   biased;
    logic [FRAC_W-1:0]      frac;
    trap_e                  tcode;

    // Normalize, round and pack
    always_comb begin
        high   = prod[P-1];
        keep   = high ? prod[P-1 -: N] : prod[P-2 -: N];
        rbit   = high ? prod[P-1-N]    : prod[P-2-N];
        rsum   = {1'b0, keep} + {{N{1'b0}}, rbit};
        inc    = EW'(high) + EW'(rsum[N]);
        e_fin  = exp_sum + inc;
        biased = e_fin + BIAS;
        frac   = rsum[FRAC_W-1:0];
        if (zero)                                       tcode = TRAP_NONE;
        else if (e_fin < E_MIN || (e_fin == E_MIN && frac == '0)) tcode = TRAP_UNDER;
        else if (e_fin > E_MAX)                         tcode = TRAP_OVER;
        else                                            tcode = TRAP_NONE;
        word = zero ? '0 : {sign, biased[EXP_W-1:0], frac};
        trap = tcode;
    end
endmodule

// File: rtl/fpm_mul.sv
// fpm_mul: sequential multiplier for 32-bit sign-magnitude excess-256
// floating-point words. Accepts start when idle, runs one partial product
// per cycle, then packs the product with a trap code.
// Assumes: operands are valid at the accepting edge only.
module fpm_mul #(
    parameter int EXP_W  = 9,
    parameter int FRAC_W = 22
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [EXP_W+FRAC_W:0]   op_a,
    input  logic [EXP_W+FRAC_W:0]   op_b,
    output logic                    busy,
    output logic                    done,
    output logic [EXP_W+FRAC_W:0]   result,
    output logic [1:0]              trap
);
    import fpm_pkg::*;

    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int N      = FRAC_W + 1;
    localparam int EW     = EXP_W + 2;

    state_e                 state_q;
    logic                   sa, sb, za, zb;
    logic signed [EW-1:0]   ea, eb;
    logic [N-1:0]           ma, mb;
    logic                   sign_q, zero_q;
    logic signed [EW-1:0]   exp_q;
    logic                   accept, load, step, last;
    logic [2*N-1:0]         prod;
    logic [WORD_W-1:0]      pk_word;
    logic [1:0]             pk_trap;

    fpm_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unp_a (
        .word(op_a), .sign(sa), .exp_u(ea), .mant(ma), .is_zero(za));

    fpm_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unp_b (
        .word(op_b), .sign(sb), .exp_u(eb), .mant(mb), .is_zero(zb));

    fpm_shift_add #(.N(N)) u_core (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step),
        .mcand_in(ma), .mplier_in(mb), .prod(prod), .last(last));

    fpm_pack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_pack (
        .prod(prod), .exp_sum(exp_q), .sign(sign_q), .zero(zero_q),
        .word(pk_word), .trap(pk_trap));

    // Handshake decode
    always_comb begin
        accept = (state_q == ST_IDLE) && start;
        load   = accept;
        step   = (state_q == ST_RUN);
        busy   = (state_q != ST_IDLE);
    end

    // Sequencer, operand side-information capture and result register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sign_q  <= 1'b0;
            zero_q  <= 1'b0;
            exp_q   <= '0;
            done    <= 1'b0;
            result  <= '0;
            trap    <= '0;
        end else begin
            done <= 1'b0;
            case (state_q)
                ST_IDLE: if (accept) begin
                    sign_q  <= sa ^ sb;
                    zero_q  <= za | zb;
                    exp_q   <= ea + eb;
                    state_q <= ST_RUN;
                end
                ST_RUN: if (last) state_q <= ST_PACK;
                ST_PACK: begin
                    result  <= pk_word;
                    trap    <= pk_trap;
                    done    <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && busy)); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy); // R8
    AST_IGNORE_START: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy) |=> ($stable(sign_q) && $stable(exp_q) && $stable(zero_q))); // R9
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !done) |-> ($stable(result) && $stable(trap))); // R10
    AST_ZERO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && zero_q) |-> (result == '0 && trap == 2'd0)); // R2
    AST_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !zero_q) |-> (result[WORD_W-1] == sign_q)); // R3
    AST_TRAP_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        trap != 2'd3); // R6
endmodule

// File: tb/sim_fpm_mul.sv
// sim_fpm_mul: behavioural reference model compared with the design on
// every clock, driven with directed and random operand pairs.
module sim_fpm_mul;
    localparam int LAT = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        busy, done;
    logic [31:0] result;
    logic [1:0]  trap;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cycles = 0;
    bit    cmp_en = 1'b0;
    bit    finished = 1'b0;
    string cur_req = "R1";

    // reference model state
    int        m_cnt = 0;
    bit        m_done = 1'b0;
    bit [31:0] m_res = '0, p_res = '0;
    bit [1:0]  m_trap = '0, p_trap = '0;

    fpm_mul u0 (.clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
                .busy(busy), .done(done), .result(result), .trap(trap));

    always #5 clk = ~clk;

    // Behavioural product of two packed words
    function automatic void ref_mul(input bit [31:0] a, input bit [31:0] b,
                                    output bit [31:0] w, output bit [1:0] t);
        longint ma, mb, p, f;
        int     e;
        if (a[30:0] == 0 || b[30:0] == 0) begin
            w = 32'h0; t = 2'd0;
            return;
        end
        ma = (longint'(1) << 22) | longint'(a[21:0]);
        mb = (longint'(1) << 22) | longint'(b[21:0]);
        e  = (int'(a[30:22]) - 256) + (int'(b[30:22]) - 256);
        p  = ma * mb;
        if (p >= (longint'(1) << 45)) begin p = p >> 1; e = e + 1; end
        p = p + (longint'(1) << 21);
        if (p >= (longint'(1) << 45)) e = e + 1;
        f = (p >> 22) & 64'h3FFFFF;
        if (e < -256 || (e == -256 && f == 0)) t = 2'd1;
        else if (e > 255)                      t = 2'd2;
        else                                   t = 2'd0;
        w = {a[31] ^ b[31], 9'((e + 256) & 511), 22'(f)};
    endfunction

    // Model advances on the same edges as the design
    always @(posedge clk) begin
        cycles = cycles + 1;
        if (!rst_n) begin
            m_cnt = 0; m_done = 1'b0; m_res = '0; m_trap = '0;
        end else begin
            m_done = 1'b0;
            if (m_cnt > 0) begin
                m_cnt = m_cnt - 1;
                if (m_cnt == 0) begin
                    m_done = 1'b1; m_res = p_res; m_trap = p_trap;
                end
            end else if (start) begin
                ref_mul(op_a, op_b, p_res, p_trap);
                m_cnt = LAT;
            end
        end
    end

    task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp_v);
        n_cmp = n_cmp + 1;
        if (act !== exp_v) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual %h expected %h at cycle %0d", req, act, exp_v, cycles);
        end
    endtask

    // Compare every cycle away from the active edge
    always @(negedge clk) begin
        if (cmp_en && !finished) begin
            cmp("R8 busy", 32'(busy), 32'(m_cnt > 0));
            cmp("R8 done", 32'(done), 32'(m_done));
            cmp({cur_req, " R10 result"}, result, m_res);
            cmp({cur_req, " R10 trap"}, 32'(trap), 32'(m_trap));
        end
    end

    task automatic mul(input logic [31:0] a, input logic [31:0] b, input string req);
        cur_req = req;
        @(negedge clk);
        op_a = a; op_b = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (LAT) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        cmp_en = 1'b1;                         // R1 checked while in reset
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);             // R1 after release
        mul(32'h40000000, 32'h40000000, "R4");  // 1.0 * 1.0
        mul(32'h40200000, 32'h40200000, "R4");  // 1.5 * 1.5, renormalize
        mul(32'hC0200000, 32'h40600000, "R3");  // negative * positive
        mul(32'hC0200000, 32'hC1000000, "R3");  // negative * negative
        mul(32'h00000000, 32'h41234567, "R2");  // +0 operand
        mul(32'h80000000, 32'hC0000000, "R2");  // -0 operand
        mul(32'h3F000001, 32'h80000000, "R2");  // -0 multiplier
        mul(32'h401A8279, 32'h401A827A, "R5");  // rounding carry
        mul(32'h403FFFFF, 32'h40000003, "R5");  // truncation below half LSB
        mul(32'h20000000, 32'h20000000, "R6");  // exponent -256, zero fraction
        mul(32'h10000000, 32'h10000000, "R6");  // deep underflow
        mul(32'h20000000, 32'h20200000, "R6");  // exponent -256, nonzero fraction
        mul(32'h7FC00000, 32'h40000000, "R7");  // exponent +255 exact
        mul(32'h7FC00000, 32'h40400000, "R7");  // exponent +256
        mul(32'h7F800000, 32'hFF800000, "R7");  // large overflow, negative
        // R9: start pulses while busy with other operands
        cur_req = "R9";
        @(negedge clk);
        op_a = 32'h40200000; op_b = 32'h40200000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        op_a = 32'h7F800000; op_b = 32'h7F800000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        op_a = 32'h00000000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (LAT) @(negedge clk);
        // random operand pairs
        for (int i = 0; i < 150; i++) begin
            mul($urandom, $urandom, "R4 R5 R6 R7");
        end
        repeat (3) @(negedge clk);
        finish_run();
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_bad = n_bad + 1;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end
endmodule